// File: doc/BRIEF.md
# SPI Slave Register-Access Frame Engine

This block is a serial peripheral slave that handles fixed-length transfers. Each transfer is 24 bits, most significant bit first. It turns every transfer into one operation on a small bank of 16-bit registers. The first eight bits a master sends are a command byte: the operation in the two top bits and a six-bit register address below them. The next sixteen bits carry write data.

While the master clocks its bits in, the block answers in the same transfer. It first sends a status byte, then a 16-bit word chosen by the command. That word is the register's present value for reads, read-and-clear and writes, so a write returns the value it replaces. For the device-information operation the word comes from a computed identification space.

The bus runs in mode 0: data is sampled on the rising clock edge and the reply changes on the falling edge. The pins are oversampled by the system clock through a synchroniser. A write or a clear is committed only when chip select rises after exactly 24 clock pulses. Any other count drops the command and raises a flag that the next status byte reports.

Top module: `spi_frame_engine`

## Requirements
- R1: `sdo_oe` is 0 while chip select is high and after reset, and 1 during a transfer. `sdo` is 0 after reset.
- R2: The first eight reply bits are a status byte sampled when chip select falls. Bit 7 is the rejected-transfer flag and bits 6..0 are `dev_flags`.
- R3: Each transfer is the command byte followed by a 16-bit data word, MSB first. Command bits 7..6 are the operation and bits 5..0 are the address. The command takes effect at the 8th rising clock.
- R4: Operation 00 (read) returns the current content of the addressed register in reply bits 15..0.
- R5: Operation 01 (write) returns the register's old content. The 16 data bits are stored when chip select rises, but only if exactly 24 rising clocks were counted.
- R6: A write or read-and-clear ending with any count other than 24 (0, 8, 23, 25, ...) leaves every register unchanged.
- R7: Operation 10 (read-and-clear) returns the content and then zeroes the register, only on a transfer of exactly 24 clocks.
- R8: Operation 11 returns the device-information word. For addresses below `DEVINFO_DEPTH` (4) the word is `{DEVICE_CODE, 2'b00, addr}` with `DEVICE_CODE` = 8'hC5. Other addresses return 0.
- R9: Address 6'h3E reads as `{8'h00, FRAME_ID}` with `FRAME_ID` = 8'h42. Writes and clears to it have no effect.
- R10: The rejected-transfer flag is set when a transfer ends with a count other than 24. It is cleared when a transfer ends with exactly 24. It resets to 0.
- R11: Addresses other than 0..`NUM_REGS`-1 (8) and 6'h3E read as 0 and ignore writes.
- R12: `sdo` changes only in response to a falling serial clock or the falling edge of chip select. It is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| dev_flags | input | 7 | Device condition bits reported in the status byte |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | Output enable for the reply pin (tri-state control) |

## Verification
The bench targets transfers that stop at 0, 7, 8 or 23 clocks, or run on to 25. A design that counted loosely would commit those writes or clears, and a design with a stale flag would misreport the next status byte. Writes are always followed by reads of the same register, so a design that returned the new value, or committed before chip select rose, shows up in the reply word. Writes to the identification address and to unbacked addresses are read back to catch a decoder that aliases them onto real registers. Reply bits are sampled twice per clock pulse, which exposes a design that moves `sdo` on the rising edge.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int CMD_W      = 8;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int FRAME_BITS = CMD_W + WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_RDCLR   = 2'b10,
    OP_DEVINFO = 2'b11
  } op_e;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Identification word for the device-information space
  function automatic word_t devinfo_word(addr_t a, logic [7:0] code, int depth);
    if (int'(a) < depth) return {code, 2'b00, a};
    return '0;
  endfunction

  // Reply bit sent after idx rising clocks; zero past the frame
  function automatic logic reply_bit(logic [FRAME_BITS-1:0] r, cnt_t idx);
    if (int'(idx) < FRAME_BITS) return r[FRAME_BITS-1-int'(idx)];
    return 1'b0;
  endfunction

  // Clock counter that stops one beyond the frame length
  function automatic cnt_t count_step(cnt_t c);
    if (int'(c) > FRAME_BITS) return c;
    return c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_s,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic [2:0] stg [STAGES];
  logic       cs_d, sck_d;
  logic       sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= 3'b100;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      stg[0] <= {cs_n, sck, sdi};
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_s     = stg[STAGES-1][2];
  assign sck_s    = stg[STAGES-1][1];
  assign sdi_s    = stg[STAGES-1][0];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       sdi_s,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic [6:0] dev_flags,
  input  word_t      rd_word,
  output op_e        peek_op,
  output addr_t      peek_addr,
  output logic       cmd_latch,
  output op_e        op_q,
  output addr_t      addr_q,
  output word_t      wdata,
  output logic       frame_start,
  output logic       frame_end,
  output logic       frame_ok,
  output cnt_t       bit_cnt,
  output logic       bad_flag,
  output logic       sdo,
  output logic       sdo_oe
);
  logic       in_frame, rise_ev, fall_ev;
  logic [7:0] status_q;
  word_t      data_q;
  word_t      sh;
  logic [CMD_W-1:0] next_cmd;

  assign in_frame    = ~cs_s;
  assign rise_ev     = sck_rise & in_frame;
  assign fall_ev     = sck_fall & in_frame;
  assign frame_start = cs_fall;
  assign frame_end   = cs_rise;
  assign frame_ok    = frame_end && (bit_cnt == cnt_t'(FRAME_BITS));
  assign next_cmd    = {sh[CMD_W-2:0], sdi_s};
  assign peek_op     = op_e'(next_cmd[CMD_W-1 -: 2]);
  assign peek_addr   = next_cmd[ADDR_W-1:0];
  assign cmd_latch   = rise_ev && (bit_cnt == cnt_t'(CMD_W - 1));
  assign wdata       = sh;
  assign sdo_oe      = in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh       <= '0;
      status_q <= '0;
      data_q   <= '0;
      op_q     <= OP_READ;
      addr_q   <= '0;
      sdo      <= 1'b0;
    end else if (frame_start) begin
      bit_cnt  <= '0;
      status_q <= {bad_flag, dev_flags};
      data_q   <= '0;
      sdo      <= bad_flag;
    end else if (rise_ev) begin
      sh      <= {sh[WORD_W-2:0], sdi_s};
      bit_cnt <= count_step(bit_cnt);
      if (cmd_latch) begin
        op_q   <= peek_op;
        addr_q <= peek_addr;
        data_q <= rd_word;
      end
    end else if (fall_ev) begin
      sdo <= reply_bit({status_q, data_q}, bit_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bad_flag <= 1'b0;
    else if (frame_end) bad_flag <= (bit_cnt != cnt_t'(FRAME_BITS));
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_fe_pkg::*;
#(
  parameter int         NUM_REGS      = 8,
  parameter logic [7:0] FRAME_ID      = 8'h42,
  parameter logic [7:0] DEVICE_CODE   = 8'hC5,
  parameter int         DEVINFO_DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  op_e   peek_op,
  input  addr_t peek_addr,
  input  op_e   op_q,
  input  addr_t addr_q,
  input  word_t wdata,
  input  logic  frame_ok,
  output word_t rd_word,
  output logic  commit_we,
  output logic  clear_en
);
  localparam addr_t ID_ADDR = addr_t'(6'h3E);

  word_t regs [NUM_REGS];
  logic  hit_q;

  assign hit_q     = int'(addr_q) < NUM_REGS;
  assign commit_we = frame_ok && (op_q == OP_WRITE) && hit_q;
  assign clear_en  = frame_ok && (op_q == OP_RDCLR) && hit_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    word_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (int'(addr_q) == i) begin
        if (commit_we)     q <= wdata;
        else if (clear_en) q <= '0;
      end
    end
    assign regs[i] = q;
  end

  always_comb begin
    rd_word = '0;
    if (peek_op == OP_DEVINFO) begin
      rd_word = devinfo_word(peek_addr, DEVICE_CODE, DEVINFO_DEPTH);
    end else if (peek_addr == ID_ADDR) begin
      rd_word = {8'h00, FRAME_ID};
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (int'(peek_addr) == i) rd_word = regs[i];
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_fe_pkg::*;
#(
  parameter int         NUM_REGS      = 8,
  parameter logic [7:0] FRAME_ID      = 8'h42,
  parameter logic [7:0] DEVICE_CODE   = 8'hC5,
  parameter int         DEVINFO_DEPTH = 4,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic [6:0] dev_flags,
  output logic       sdo,
  output logic       sdo_oe
);
  logic  cs_sync, sdi_sync, sck_rise, sck_fall, cs_fall, cs_rise;
  logic  frame_start, frame_end, frame_ok, cmd_latch, bad_flag;
  logic  commit_we, clear_en;
  op_e   peek_op, op_q;
  addr_t peek_addr, addr_q;
  word_t rd_word, wdata;
  cnt_t  bit_cnt;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_s(cs_sync), .sdi_s(sdi_sync), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  spi_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .sdi_s(sdi_sync),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .dev_flags(dev_flags), .rd_word(rd_word),
    .peek_op(peek_op), .peek_addr(peek_addr), .cmd_latch(cmd_latch),
    .op_q(op_q), .addr_q(addr_q), .wdata(wdata),
    .frame_start(frame_start), .frame_end(frame_end), .frame_ok(frame_ok),
    .bit_cnt(bit_cnt), .bad_flag(bad_flag), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  spi_regbank #(
    .NUM_REGS(NUM_REGS), .FRAME_ID(FRAME_ID),
    .DEVICE_CODE(DEVICE_CODE), .DEVINFO_DEPTH(DEVINFO_DEPTH)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .peek_op(peek_op), .peek_addr(peek_addr),
    .op_q(op_q), .addr_q(addr_q), .wdata(wdata), .frame_ok(frame_ok),
    .rd_word(rd_word), .commit_we(commit_we), .clear_en(clear_en)
  );
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk
  import spi_fe_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic  clk,
  input logic  rst_n,
  input logic  cs_sync,
  input logic  sck_fall,
  input logic  frame_start,
  input logic  frame_end,
  input logic  cmd_latch,
  input logic  commit_we,
  input logic  clear_en,
  input logic  bad_flag,
  input cnt_t  bit_cnt,
  input addr_t addr_q,
  input logic  sdo,
  input logic  sdo_oe
);
  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |-> !sdo_oe);

  assert_cmd_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_latch |-> (bit_cnt == cnt_t'(CMD_W - 1)));

  assert_write_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (bit_cnt == cnt_t'(FRAME_BITS)));

  assert_bad_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && bit_cnt != cnt_t'(FRAME_BITS)) |-> !(commit_we || clear_en));

  assert_id_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we || clear_en) |-> (int'(addr_q) < NUM_REGS));

  assert_flag_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bad_flag == ($past(bit_cnt) != cnt_t'(FRAME_BITS))));

  assert_sdo_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !frame_start) |=> $stable(sdo));
endmodule

bind spi_frame_engine spi_frame_engine_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .sck_fall(sck_fall),
  .frame_start(frame_start), .frame_end(frame_end), .cmd_latch(cmd_latch),
  .commit_we(commit_we), .clear_en(clear_en), .bad_flag(bad_flag),
  .bit_cnt(bit_cnt), .addr_q(addr_q), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/sim_spi_frame_engine.sv
`timescale 1ns/1ps
module sim_spi_frame_engine;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [6:0] dev_flags = '0;
  logic       sdo, sdo_oe;

  int vectors = 0;
  int fails   = 0;

  logic [15:0] mregs [8];
  logic        mflag = 1'b0;

  always #4 clk = ~clk;

  spi_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dev_flags(dev_flags), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] op, input logic [5:0] a);
    if (op == 2'b11) return (a < 6'd4) ? {8'hC5, 2'b00, a} : 16'h0000;
    if (a == 6'h3E) return 16'h0042;
    if (a < 6'd8)   return mregs[a[2:0]];
    return 16'h0000;
  endfunction

  function automatic string data_req(input logic [1:0] op, input logic [5:0] a);
    if (op == 2'b11) return "R8";
    if (a == 6'h3E)  return "R9";
    if (a >= 6'd8)   return "R11";
    case (op)
      2'b00:   return "R4";
      2'b01:   return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic run_frame(input logic [1:0] op, input logic [5:0] a,
                           input logic [15:0] d, input int nclk);
    logic [23:0] tx, cap, expv;
    int glitches = 0;
    int nb;
    logic a_s, b_s;
    tx   = {op, a, d};
    cap  = '0;
    expv = {mflag, 7'h00, exp_word(op, a)};
    @(negedge clk);
    dev_flags = 7'($urandom);
    expv[22:16] = dev_flags;
    cs_n = 1'b0;
    sdi  = tx[23];
    repeat (HALF) @(negedge clk);
    chk(sdo_oe === 1'b1, "R1 oe in frame", {31'd0, sdo_oe}, 32'd1);
    for (int i = 0; i < nclk; i++) begin
      a_s = sdo;
      if (i < 24) cap[23-i] = a_s;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      b_s = sdo;
      if (b_s !== a_s) glitches++;
      sck = 1'b0;
      sdi = (i < 23) ? tx[22-i] : 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 oe idle", {31'd0, sdo_oe}, 32'd0);
    chk(glitches == 0, "R12 sdo moved with sck high", glitches, 0);
    nb = (nclk < 24) ? nclk : 24;
    // Status byte (R2, R10) then data word, compared over the clocks given
    for (int grp = 0; grp < 2; grp++) begin
      logic [23:0] m = '0;
      for (int i = 0; i < nb; i++)
        if ((grp == 0) == (i < 8)) m[23-i] = 1'b1;
      if (m != '0)
        chk((cap & m) == (expv & m),
            (grp == 0) ? "R2 R10 status byte" : {data_req(op, a), " R3 reply word"},
            {8'h0, cap & m}, {8'h0, expv & m});
    end
    if (nclk == 24 && a < 6'd8) begin
      if (op == 2'b01) mregs[a[2:0]] = d;
      if (op == 2'b10) mregs[a[2:0]] = 16'h0000;
    end
    mflag = (nclk != 24);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mregs[i] = 16'h0000;
    repeat (5) @(negedge clk);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1 reset outputs", {30'd0, sdo_oe, sdo}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_frame(2'b00, 6'd0, 16'h0000, 24);      // R4 reset content
    run_frame(2'b01, 6'd3, 16'hBEEF, 24);      // R5 old value returned
    run_frame(2'b00, 6'd3, 16'h0000, 24);      // R5 committed
    run_frame(2'b01, 6'd3, 16'h1111, 23);      // R6 short write
    run_frame(2'b00, 6'd3, 16'h0000, 24);      // R6 R10 flag set, value kept
    run_frame(2'b01, 6'd3, 16'h2222, 25);      // R6 long write
    run_frame(2'b10, 6'd3, 16'h0000, 25);      // R7 no clear on bad count
    run_frame(2'b10, 6'd3, 16'h0000, 24);      // R7 clear
    run_frame(2'b00, 6'd3, 16'h0000, 24);      // R7 reads zero
    run_frame(2'b01, 6'd5, 16'h7A5C, 8);       // R6 only command byte
    run_frame(2'b00, 6'd5, 16'h0000, 0);       // R10 zero-clock frame
    run_frame(2'b00, 6'd5, 16'h0000, 24);      // R10 flag reported then cleared
    run_frame(2'b11, 6'd2, 16'h0000, 24);      // R8
    run_frame(2'b11, 6'd9, 16'h0000, 24);      // R8 outside space
    run_frame(2'b01, 6'h3E, 16'hFFFF, 24);     // R9 write ignored
    run_frame(2'b10, 6'h3E, 16'h0000, 24);     // R9 clear ignored
    run_frame(2'b00, 6'h3E, 16'h0000, 24);     // R9
    run_frame(2'b01, 6'h20, 16'hABCD, 24);     // R11
    run_frame(2'b00, 6'h20, 16'h0000, 24);     // R11 reads zero

    for (int k = 0; k < 130; k++) begin
      logic [1:0]  op = 2'($urandom);
      logic [5:0]  a;
      int          n = 24;
      int          r = $urandom % 4;
      case (r)
        0, 1:    a = 6'($urandom % 8);
        2:       a = 6'h3E;
        default: a = 6'($urandom);
      endcase
      if ($urandom % 6 == 0) begin
        case ($urandom % 5)
          0: n = 0;
          1: n = 7;
          2: n = 8;
          3: n = 23;
          default: n = 25;
        endcase
      end
      run_frame(op, a, 16'($urandom), n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule